// File: doc/BRIEF.md
# Capture Mode and Trigger Position Controller

This block supervises a single capture into a circular sample memory. Software writes a mode byte. The byte turns memory writing and reading on or off, arms or clears the trigger, forces a stop, fires a trigger by software, or returns the write pointer to the start. Each accepted sample advances a write address that wraps around the memory. A sticky flag records that the memory has wrapped at least once. The trigger evaluator outside the block delivers a single strobe. The memory itself is also outside the block.

Once a trigger is accepted, the block stores the write address of that cycle. It then counts whole memory rows, up to a programmed limit. When the limit is reached it stops writing, raises a post-trigger-done flag and stores the stop address. A status byte and the two stored addresses are read one byte at a time through a small select port. Each address is zero-extended to 24 bits and read as low, middle and upper bytes.

Top module: `capture_ctrl`

## Requirements
- R1: The status byte (select 0) carries write enable in bit 0, read enable in bit 1, trigger enable in bit 3, wrapped in bit 4, triggered in bit 5 and post-trigger done in bit 6. Bits 2 and 7 read zero, as does select 7. After reset the status byte and the write address are zero.
- R2: When `sample_valid` is high, write enable is set and neither a mode write nor a row write is present, the block pulses `mem_wr_strobe`. In that cycle `wr_addr` is the address being written, and the address then advances by one modulo 2^ADDR_W. With write enable clear, samples are ignored and the address holds.
- R3: An address step from the highest value back to zero sets the wrapped flag. The flag is cleared only by the init bit; a trigger reset leaves it unchanged.
- R4: A trigger comes either from `trig_strobe` or from mode bit 5. It is accepted only while trigger enable and write enable are set and the triggered flag is clear. A strobe that arrives while already triggered has no effect.
- R5: In the cycle a trigger is accepted, the trigger position takes the current write address. Selects 1, 2 and 3 return its bits 7:0, 15:8 and 23:16.
- R6: After a trigger, each sample written at the last event of a row (low EVT_W address bits all ones) counts one row. When the count reaches the post-trigger row value, write enable clears, post-trigger done sets and the stop position takes the next address to be written. A value of zero stops in the trigger cycle itself.
- R7: Mode bit 4 (forced stop) clears write enable and stores the current address as the stop position, even when no trigger has occurred. Selects 4, 5 and 6 return the stop position bytes, from low to upper.
- R8: Mode bit 2 (trigger reset) clears the triggered flag, the done flag and the row count. A software trigger written in the same byte is ignored.
- R9: Mode bit 7 (init) sets the write address to zero and clears the wrapped flag.
- R10: A row write, when no mode write is present in the same cycle, sets the address to the row value shifted left by EVT_W. During a mode write, samples, trigger strobes and row writes are dropped.
- R11: A mode write loads write enable from bit 0 (forced low if bit 4 is set), read enable from bit 1 and trigger enable from bit 3. These appear on `mem_wr_en` and `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode byte write strobe |
| mode_wdata | input | 8 | Mode command byte |
| row_we | input | 1 | Row register write strobe |
| row_wdata | input | ADDR_W-EVT_W | Row to start writing from |
| post_we | input | 1 | Post-trigger row count write strobe |
| post_wdata | input | ADDR_W-EVT_W | Rows to capture after the trigger |
| sample_valid | input | 1 | A sample is ready to be stored |
| trig_strobe | input | 1 | Trigger condition met |
| rd_sel | input | 3 | Readout byte select |
| rd_data | output | 8 | Selected readout byte |
| mem_wr_en | output | 1 | Write enable state |
| mem_rd_en | output | 1 | Read enable state |
| mem_wr_strobe | output | 1 | Store the sample at wr_addr this cycle |
| wr_addr | output | ADDR_W | Current write address |

## Verification
The bench builds the block with ADDR_W=10 and EVT_W=3. With these values a row holds eight events and the memory holds 1024, so a full wrap takes about a thousand samples and a post-trigger window takes only a few rows. The upper readout bytes are then always zero-extended, which checks the padding path. The directed part covers triggers, row-counted stops, forced stops, wraps, row loads and command collisions. A random phase then mixes in mode writes, row loads and new row-count values.

// File: rtl/cap_pkg.sv
package cap_pkg;
    // mode command bit positions (decoded by software-facing writer)
    localparam int MB_WEN  = 0;
    localparam int MB_REN  = 1;
    localparam int MB_TRES = 2;
    localparam int MB_TEN  = 3;
    localparam int MB_STOP = 4;
    localparam int MB_SWT  = 5;
    localparam int MB_INIT = 7;

    // status byte bit positions
    localparam int ST_WEN  = 0;
    localparam int ST_REN  = 1;
    localparam int ST_TEN  = 3;
    localparam int ST_WRAP = 4;
    localparam int ST_TRIG = 5;
    localparam int ST_DONE = 6;

    typedef struct packed {
        logic wen;
        logic ren;
        logic tres;
        logic ten;
        logic stop;
        logic swt;
        logic init;
    } mode_cmd_t;

    typedef enum logic [2:0] {
        SEL_STATUS   = 3'd0,
        SEL_TRIG_LO  = 3'd1,
        SEL_TRIG_MID = 3'd2,
        SEL_TRIG_HI  = 3'd3,
        SEL_STOP_LO  = 3'd4,
        SEL_STOP_MID = 3'd5,
        SEL_STOP_HI  = 3'd6,
        SEL_NONE     = 3'd7
    } rd_sel_e;
endpackage

// File: rtl/cap_cmd_decode.sv
module cap_cmd_decode
    import cap_pkg::*;
(
    input  logic       we,
    input  logic [7:0] wdata,
    output mode_cmd_t  cmd
);
    always_comb begin
        cmd.wen  = we & wdata[MB_WEN];
        cmd.ren  = we & wdata[MB_REN];
        cmd.tres = we & wdata[MB_TRES];
        cmd.ten  = we & wdata[MB_TEN];
        cmd.stop = we & wdata[MB_STOP];
        cmd.swt  = we & wdata[MB_SWT];
        cmd.init = we & wdata[MB_INIT];
    end
endmodule

// File: rtl/cap_readout.sv
module cap_readout
    import cap_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              wen,
    input  logic              ren,
    input  logic              ten,
    input  logic              wrapped,
    input  logic              trig,
    input  logic              done,
    input  logic [ADDR_W-1:0] tpos,
    input  logic [ADDR_W-1:0] spos,
    input  logic [2:0]        rd_sel,
    output logic [7:0]        rd_data
);
    localparam int POS_W = 24;

    logic [POS_W-1:0] tpos_x;
    logic [POS_W-1:0] spos_x;
    logic [7:0]       status;

    always_comb begin
        tpos_x = POS_W'(tpos);
        spos_x = POS_W'(spos);
        status = 8'h00;
        status[ST_WEN]  = wen;
        status[ST_REN]  = ren;
        status[ST_TEN]  = ten;
        status[ST_WRAP] = wrapped;
        status[ST_TRIG] = trig;
        status[ST_DONE] = done;
        case (rd_sel_e'(rd_sel))
            SEL_STATUS:   rd_data = status;
            SEL_TRIG_LO:  rd_data = tpos_x[7:0];
            SEL_TRIG_MID: rd_data = tpos_x[15:8];
            SEL_TRIG_HI:  rd_data = tpos_x[23:16];
            SEL_STOP_LO:  rd_data = spos_x[7:0];
            SEL_STOP_MID: rd_data = spos_x[15:8];
            SEL_STOP_HI:  rd_data = spos_x[23:16];
            default:      rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import cap_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int EVT_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_we,
    input  logic [7:0]              mode_wdata,
    input  logic                    row_we,
    input  logic [ADDR_W-EVT_W-1:0] row_wdata,
    input  logic                    post_we,
    input  logic [ADDR_W-EVT_W-1:0] post_wdata,
    input  logic                    sample_valid,
    input  logic                    trig_strobe,
    input  logic [2:0]              rd_sel,
    output logic [7:0]              rd_data,
    output logic                    mem_wr_en,
    output logic                    mem_rd_en,
    output logic                    mem_wr_strobe,
    output logic [ADDR_W-1:0]       wr_addr
);
    localparam int ROW_W = ADDR_W - EVT_W;
    localparam int CNT_W = ROW_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wrapped;
        logic              wen;
        logic              ren;
        logic              ten;
        logic              trig;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [ROW_W-1:0]  post;
        logic [ADDR_W-1:0] tpos;
        logic [ADDR_W-1:0] spos;
    } cap_state_t;

    cap_state_t state_d, state_q;
    mode_cmd_t  cmd;
    logic       strobe;
    logic       sw_ok;
    logic       accept;
    logic       row_end;

    cap_cmd_decode u_dec (
        .we    (mode_we),
        .wdata (mode_wdata),
        .cmd   (cmd)
    );

    always_comb begin
        state_d = state_q;
        strobe  = sample_valid && state_q.wen && !mode_we && !row_we;
        sw_ok   = cmd.swt && state_q.ten && state_q.wen && !state_q.trig
                  && !cmd.tres && !cmd.stop;
        accept  = trig_strobe && state_q.ten && state_q.wen && !state_q.trig;
        row_end = &state_q.addr[EVT_W-1:0];

        if (post_we) state_d.post = post_wdata;

        if (mode_we) begin
            state_d.wen = cmd.wen && !cmd.stop;
            state_d.ren = cmd.ren;
            state_d.ten = cmd.ten;
            if (cmd.tres) begin
                state_d.trig = 1'b0;
                state_d.done = 1'b0;
                state_d.cnt  = '0;
            end
            if (cmd.init) begin
                state_d.addr    = '0;
                state_d.wrapped = 1'b0;
            end
            if (cmd.stop) state_d.spos = state_d.addr;
            if (sw_ok) begin
                state_d.trig = 1'b1;
                state_d.tpos = state_q.addr;
                state_d.cnt  = '0;
                if (state_q.post == '0) begin
                    state_d.wen  = 1'b0;
                    state_d.done = 1'b1;
                    state_d.spos = state_d.addr;
                end
            end
        end else if (row_we) begin
            state_d.addr = {row_wdata, {EVT_W{1'b0}}};
        end else begin
            if (strobe) begin
                state_d.addr = state_q.addr + 1'b1;
                if (state_d.addr == '0) state_d.wrapped = 1'b1;
                if (state_q.trig && !state_q.done && row_end) begin
                    state_d.cnt = state_q.cnt + 1'b1;
                    if (state_d.cnt >= CNT_W'(state_q.post)) begin
                        state_d.wen  = 1'b0;
                        state_d.done = 1'b1;
                        state_d.spos = state_d.addr;
                    end
                end
            end
            if (accept) begin
                state_d.trig = 1'b1;
                state_d.tpos = state_q.addr;
                state_d.cnt  = '0;
                if (state_q.post == '0) begin
                    state_d.wen  = 1'b0;
                    state_d.done = 1'b1;
                    state_d.spos = state_d.addr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    cap_readout #(.ADDR_W(ADDR_W)) u_rd (
        .wen     (state_q.wen),
        .ren     (state_q.ren),
        .ten     (state_q.ten),
        .wrapped (state_q.wrapped),
        .trig    (state_q.trig),
        .done    (state_q.done),
        .tpos    (state_q.tpos),
        .spos    (state_q.spos),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    assign mem_wr_en     = state_q.wen;
    assign mem_rd_en     = state_q.ren;
    assign mem_wr_strobe = strobe;
    assign wr_addr       = state_q.addr;
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_we,
    input logic [7:0]        mode_wdata,
    input logic [ADDR_W-1:0] addr,
    input logic              wen,
    input logic              wrapped,
    input logic              trig,
    input logic              done,
    input logic [ADDR_W-1:0] tpos,
    input logic [ADDR_W-1:0] spos,
    input logic              strobe
);
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> addr == ADDR_W'($past(addr) + 1'b1));

    assert_tres_keeps_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata[2] && !mode_wdata[7])
        |=> (wrapped == $past(wrapped)) && !trig && !done);

    assert_trig_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig) |-> tpos == $past(addr));

    assert_done_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !wen);

    assert_force_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && mode_wdata[4]) |=> !wen && (spos == addr));
endmodule

bind capture_ctrl cap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .addr       (state_q.addr),
    .wen        (state_q.wen),
    .wrapped    (state_q.wrapped),
    .trig       (state_q.trig),
    .done       (state_q.done),
    .tpos       (state_q.tpos),
    .spos       (state_q.spos),
    .strobe     (mem_wr_strobe)
);

// File: tb/tb_capture_ctrl.sv
module tb_capture_ctrl;
    localparam int A  = 10;
    localparam int E  = 3;
    localparam int RW = A - E;
    localparam int CLK_PERIOD = 10;
    localparam int AMASK = (1 << A) - 1;
    localparam int EMASK = (1 << E) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0;
    logic [7:0]    mode_wdata = 8'h00;
    logic          row_we = 1'b0;
    logic [RW-1:0] row_wdata = '0;
    logic          post_we = 1'b0;
    logic [RW-1:0] post_wdata = '0;
    logic          sample_valid = 1'b0;
    logic          trig_strobe = 1'b0;
    logic [2:0]    rd_sel = 3'd0;
    logic [7:0]    rd_data;
    logic          mem_wr_en, mem_rd_en, mem_wr_strobe;
    logic [A-1:0]  wr_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int sel_rot = 0;

    // behavioural reference state
    int m_addr, m_cnt, m_post, m_tpos, m_spos;
    bit m_wrap, m_wen, m_ren, m_ten, m_trig, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    capture_ctrl #(.ADDR_W(A), .EVT_W(E)) dut (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .row_we(row_we), .row_wdata(row_wdata), .post_we(post_we),
        .post_wdata(post_wdata), .sample_valid(sample_valid),
        .trig_strobe(trig_strobe), .rd_sel(rd_sel), .rd_data(rd_data),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
        .mem_wr_strobe(mem_wr_strobe), .wr_addr(wr_addr)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_status();
        return (m_wen ? 1 : 0) | (m_ren ? 2 : 0) | (m_ten ? 8 : 0) |
               (m_wrap ? 16 : 0) | (m_trig ? 32 : 0) | (m_done ? 64 : 0);
    endfunction

    function automatic int m_byte(input int sel);
        case (sel)
            0: return m_status();
            1: return m_tpos & 255;
            2: return (m_tpos >> 8) & 255;
            3: return (m_tpos >> 16) & 255;
            4: return m_spos & 255;
            5: return (m_spos >> 8) & 255;
            6: return (m_spos >> 16) & 255;
            default: return 0;
        endcase
    endfunction

    function automatic string sel_tag(input int sel);
        if (sel == 0 || sel == 7) return "R1";
        if (sel <= 3) return "R5";
        return "R7";
    endfunction

    task automatic model_reset();
        m_addr = 0; m_cnt = 0; m_post = 0; m_tpos = 0; m_spos = 0;
        m_wrap = 0; m_wen = 0; m_ren = 0; m_ten = 0; m_trig = 0; m_done = 0;
    endtask

    task automatic model_update(input bit mw, input int md, input bit rw, input int rd,
                                input bit pw, input int pd, input bit sv, input bit ts);
        int old_addr;
        int new_post;
        bit sw, acc, old_trig, old_done, old_wen, old_ten;
        old_addr = m_addr; old_trig = m_trig; old_done = m_done;
        old_wen = m_wen; old_ten = m_ten;
        new_post = pw ? pd : m_post;
        if (mw) begin
            sw = md[5] && old_ten && old_wen && !old_trig && !md[2] && !md[4];
            m_wen = md[0] && !md[4];
            m_ren = md[1];
            m_ten = md[3];
            if (md[2]) begin m_trig = 0; m_done = 0; m_cnt = 0; end
            if (md[7]) begin m_addr = 0; m_wrap = 0; end
            if (md[4]) m_spos = m_addr;
            if (sw) begin
                m_trig = 1; m_tpos = old_addr; m_cnt = 0;
                if (m_post == 0) begin m_wen = 0; m_done = 1; m_spos = m_addr; end
            end
        end else if (rw) begin
            m_addr = rd << E;
        end else begin
            acc = ts && old_ten && old_wen && !old_trig;
            if (sv && old_wen) begin
                m_addr = (old_addr + 1) & AMASK;
                if (m_addr == 0) m_wrap = 1;
                if (old_trig && !old_done && ((old_addr & EMASK) == EMASK)) begin
                    m_cnt++;
                    if (m_cnt >= m_post) begin m_wen = 0; m_done = 1; m_spos = m_addr; end
                end
            end
            if (acc) begin
                m_trig = 1; m_tpos = old_addr; m_cnt = 0;
                if (m_post == 0) begin m_wen = 0; m_done = 1; m_spos = m_addr; end
            end
        end
        m_post = new_post;
    endtask

    // one clock: compare, drive, compare combinational outputs, advance model
    task automatic step(input bit mw, input int md, input bit rw, input int rd,
                        input bit pw, input int pd, input bit sv, input bit ts);
        bit exp_strobe;
        chk(int'(wr_addr), m_addr, "R2 wr_addr");
        chk(int'(mem_wr_en), int'(m_wen), "R11 mem_wr_en");
        chk(int'(mem_rd_en), int'(m_ren), "R11 mem_rd_en");
        mode_we = mw; mode_wdata = md[7:0];
        row_we = rw; row_wdata = rd[RW-1:0];
        post_we = pw; post_wdata = pd[RW-1:0];
        sample_valid = sv; trig_strobe = ts;
        rd_sel = sel_rot[2:0];
        #1;
        chk(int'(rd_data), m_byte(sel_rot), sel_tag(sel_rot));
        exp_strobe = sv && m_wen && !mw && !rw;
        chk(int'(mem_wr_strobe), int'(exp_strobe), "R10 mem_wr_strobe");
        sel_rot = (sel_rot + 1) % 8;
        model_update(mw, md, rw, rd, pw, pd, sv, ts);
        @(negedge clk);
        mode_we = 0; row_we = 0; post_we = 0; sample_valid = 0; trig_strobe = 0;
    endtask

    task automatic mode(input int md);  step(1, md, 0, 0, 0, 0, 0, 0); endtask
    task automatic samp(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic peek(input int sel, input int exp, input string tag);
        rd_sel = sel[2:0];
        #1;
        chk(int'(rd_data), exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        peek(0, 0, "R1 reset status");
        chk(int'(wr_addr), 0, "R1 reset address");
        peek(7, 0, "R1 unused select");

        step(0, 0, 0, 0, 1, 2, 0, 0);          // post rows = 2
        mode(8'h09);
        peek(0, 8'h09, "R11 status after enable");
        samp(8);
        chk(int'(wr_addr), 8, "R2 address after eight samples");
        step(0, 0, 0, 0, 0, 0, 1, 1);          // trigger with sample at 8
        peek(1, 8, "R5 trigger low byte");
        peek(2, 0, "R5 trigger mid byte");
        peek(3, 0, "R5 trigger upper byte");
        peek(0, 8'h29, "R4 triggered status");
        samp(14);
        peek(0, 8'h29, "R6 still capturing");
        samp(1);
        peek(0, 8'h68, "R6 done status");
        peek(4, 24, "R6 stop position");
        step(0, 0, 0, 0, 0, 0, 1, 1);          // strobe and sample after stop
        peek(1, 8, "R4 retrigger ignored");
        chk(int'(wr_addr), 24, "R2 no advance when disabled");

        mode(8'h0D);
        peek(0, 8'h09, "R8 trigger reset clears flags");
        samp(1000);
        peek(0, 8'h19, "R3 wrapped set");
        chk(int'(wr_addr), 0, "R3 wrapped address");
        mode(8'h0D);
        peek(0, 8'h19, "R3 trigger reset keeps wrap");

        samp(5);
        mode(8'h18);
        peek(0, 8'h18, "R7 forced stop status");
        peek(4, 5, "R7 stop low byte");
        peek(5, 0, "R7 stop mid byte");
        peek(1, 8, "R7 trigger position untouched");

        mode(8'h80);
        peek(0, 0, "R9 init status");
        chk(int'(wr_addr), 0, "R9 init address");

        step(0, 0, 1, 3, 0, 0, 0, 0);
        chk(int'(wr_addr), 24, "R10 row load");
        step(1, 8'h09, 0, 0, 0, 0, 1, 0);
        chk(int'(wr_addr), 24, "R10 sample dropped in mode write");
        step(1, 8'h09, 1, 7, 0, 0, 0, 1);
        chk(int'(wr_addr), 24, "R10 row write dropped in mode write");
        peek(0, 8'h09, "R10 strobe dropped in mode write");

        step(0, 0, 0, 0, 1, 0, 0, 0);          // post rows = 0
        mode(8'h29);
        peek(0, 8'h68, "R4 software trigger with zero rows");
        peek(1, 24, "R5 software trigger position");
        peek(4, 24, "R6 zero-row stop position");

        mode(8'h2D);
        peek(0, 8'h09, "R8 software trigger ignored with reset");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            bit mw, rw, pw, sv, ts;
            int md;
            mw = ($urandom % 60) == 0;
            rw = ($urandom % 300) == 0;
            pw = ($urandom % 150) == 0;
            sv = ($urandom % 4) != 0;
            ts = ($urandom % 25) == 0;
            case ($urandom % 6)
                0: md = 8'h0D;
                1: md = 8'h09;
                2: md = 8'h2B;
                3: md = 8'h18;
                4: md = 8'h8D;
                default: md = 8'h0F;
            endcase
            step(mw, md, rw, $urandom % (1 << RW), pw, $urandom % 4, sv, ts);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule